// File: doc/BRIEF.md
# Complementary Dead-Time Output Stage

This block sits between a pair of PWM waveform generators and the two pins they drive. It takes the raw level of each channel and produces the final pin level and pin drive-enable for both channels. In independent mode each channel's raw level reaches its own pin after one register stage. In complementary mode, output 0 follows channel 0 and output 1 follows the inverse of channel 0. The raw level of channel 1 is not used in that mode. Each output's rising edge is held back by a programmable number of prescaled ticks, so that the two outputs are never high together.

After the dead-time stage, each channel passes through two independent inversion controls: an output inverter and a polarity-inverse control. A per-channel pin enable then decides whether the pin is driven at all. The prescaled tick comes from a clock divider outside this block, and it only sets the pace of the dead-time count.

Top module: `pwm_pair_outstage`

## Requirements
- R1: While `rst_n` is low, both dead-time stage levels are 0, so `pin_out` equals `inv_en ^ pol_en` bitwise.
- R2: With `dt_en` = 0, the stage level of output i on the clock edge after a sample equals `ch_raw[i]` at that edge: a one-cycle pass-through with no delay count.
- R3: With `dt_en` = 1, output 0 takes `ch_raw[0]` as its source and output 1 takes `~ch_raw[0]`. `ch_raw[1]` has no effect on either output.
- R4: With `dt_en` = 1 and a source high, a per-output counter starts at 0 and advances by one on each clock edge where `tick` = 1, until it equals `dt_len`. The output goes high on the first edge at which the counter equals `dt_len`. With `tick` held at 1, the output therefore rises `dt_len`+1 edges after the first edge that sees the source high.
- R5: With `dt_en` = 1, a low source drives its output low on the next edge and clears its counter.
- R6: A source high pulse too short to complete the count leaves its output low for the whole pulse.
- R7: Once `dt_en` has been 1 for one full edge, the two stage levels are never both 1.
- R8: `pin_out[i]` = stage level ^ `inv_en[i]` ^ `pol_en[i]`. Each control inverts on its own, and setting both cancels out. These controls act combinationally, after the dead-time stage.
- R9: `pin_oe[i]` follows `oe_en[i]`. When `oe_en[i]` = 0, `pin_oe[i]` is 0 whatever the waveform.
- R10: Clock edges with `tick` = 0 do not advance the dead-time counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Prescaled tick that paces the dead-time count |
| ch_raw | input | 2 | Raw channel waveform levels |
| dt_en | input | 1 | Complementary dead-time mode enable |
| dt_len | input | DT_W | Dead interval in ticks |
| inv_en | input | 2 | Per-channel output inverter enable |
| pol_en | input | 2 | Per-channel polarity-inverse enable |
| oe_en | input | 2 | Per-channel pin output enable |
| pin_out | output | 2 | Pin drive level |
| pin_oe | output | 2 | Pin drive enable |

## Verification
The stage level is registered, so a raw or mode change shows on `pin_out` one edge later. A dead-time rise comes `dt_len`+1 edges after the source rises when `tick` is always 1, and later when ticks are sparser. The inversion controls and the pin enable act in the same cycle. The bench drives every input at the falling edge and samples the outputs at the next falling edge. Its cycle model advances on each rising edge, so each comparison uses the value due in that cycle. The dead-time sweep covers intervals 0 to 4, tick spacings 1 to 3 and pulse widths 1 to 7, while `ch_raw[1]` toggles freely.

// File: rtl/pwm_os_pkg.sv
package pwm_os_pkg;

  // Source level feeding dead-time stage idx: complementary mode ties both
  // outputs to channel 0, the second one inverted.
  function automatic logic stage_src(input logic cmp_mode, input int idx,
                                     input logic lead, input logic own);
    if (!cmp_mode) return own;
    return (idx == 0) ? lead : ~lead;
  endfunction

  // Counter has consumed the full dead interval.
  function automatic logic interval_done(input logic [15:0] cnt,
                                         input logic [15:0] len);
    return cnt >= len;
  endfunction

  // Final pin level: two independent inversions after the dead-time stage.
  function automatic logic drive_level(input logic lvl, input logic inv,
                                       input logic pol);
    return lvl ^ inv ^ pol;
  endfunction

endpackage

// File: rtl/dz_delay.sv
module dz_delay #(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bypass,
  input  logic            src,
  input  logic            tick,
  input  logic [DT_W-1:0] len,
  output logic            lvl,
  output logic [DT_W-1:0] cnt
);
  import pwm_os_pkg::*;

  localparam logic [DT_W-1:0] ONE = {{(DT_W-1){1'b0}}, 1'b1};

  logic done_w;
  logic rise_w;

  assign done_w = interval_done(16'(cnt), 16'(len));
  assign rise_w = src && !lvl && done_w;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl <= 1'b0;
      cnt <= '0;
    end else if (bypass) begin
      lvl <= src;
      cnt <= '0;
    end else if (!src) begin
      lvl <= 1'b0;
      cnt <= '0;
    end else if (rise_w) begin
      lvl <= 1'b1;
    end else if (!lvl && tick) begin
      cnt <= cnt + ONE;
    end
  end

endmodule

// File: rtl/pin_stage.sv
module pin_stage (
  input  logic lvl,
  input  logic inv,
  input  logic pol,
  input  logic oe_ctl,
  output logic pin,
  output logic oe
);
  import pwm_os_pkg::*;

  assign pin = drive_level(lvl, inv, pol);
  assign oe  = oe_ctl;

endmodule

// File: rtl/pwm_pair_outstage.sv
module pwm_pair_outstage #(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic [1:0]      ch_raw,
  input  logic            dt_en,
  input  logic [DT_W-1:0] dt_len,
  input  logic [1:0]      inv_en,
  input  logic [1:0]      pol_en,
  input  logic [1:0]      oe_en,
  output logic [1:0]      pin_out,
  output logic [1:0]      pin_oe
);
  import pwm_os_pkg::*;

  localparam int NCH = 2;

  logic [NCH-1:0]           src_w;
  logic [NCH-1:0]           dz_lvl;
  logic [NCH-1:0][DT_W-1:0] dz_cnt;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign src_w[i] = stage_src(dt_en, i, ch_raw[0], ch_raw[i]);

    dz_delay #(.DT_W(DT_W)) u_dz (
      .clk    (clk),
      .rst_n  (rst_n),
      .bypass (~dt_en),
      .src    (src_w[i]),
      .tick   (tick),
      .len    (dt_len),
      .lvl    (dz_lvl[i]),
      .cnt    (dz_cnt[i])
    );

    pin_stage u_pin (
      .lvl    (dz_lvl[i]),
      .inv    (inv_en[i]),
      .pol    (pol_en[i]),
      .oe_ctl (oe_en[i]),
      .pin    (pin_out[i]),
      .oe     (pin_oe[i])
    );
  end

endmodule

// File: rtl/pwm_os_chk.sv
module pwm_os_chk #(
  parameter int DT_W = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 dt_en,
  input logic [DT_W-1:0]      dt_len,
  input logic [1:0]           ch_raw,
  input logic [1:0]           dz_lvl,
  input logic [1:0][DT_W-1:0] dz_cnt
);

  // R7
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(dt_en) |-> !(dz_lvl[0] && dz_lvl[1]));

  // R2
  pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dt_en |=> dz_lvl == $past(ch_raw));

  // R5
  low0_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dt_en && !ch_raw[0]) |=> !dz_lvl[0]);

  // R5 R3
  low1_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dt_en && ch_raw[0]) |=> !dz_lvl[1]);

  for (genvar i = 0; i < 2; i++) begin : g_rise
    // R4
    rise_after_interval_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(dz_lvl[i]) && $past(dt_en)) |-> $past(dz_cnt[i]) >= $past(dt_len));
  end

endmodule

bind pwm_pair_outstage pwm_os_chk #(.DT_W(DT_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .dt_en  (dt_en),
  .dt_len (dt_len),
  .ch_raw (ch_raw),
  .dz_lvl (dz_lvl),
  .dz_cnt (dz_cnt)
);

// File: tb/pwm_pair_outstage_tb.sv
module pwm_pair_outstage_tb;
  localparam int DT_W = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic            rst_n, tick, dt_en;
  logic [1:0]      ch_raw, inv_en, pol_en, oe_en;
  logic [DT_W-1:0] dt_len;
  logic [1:0]      pin_out, pin_oe;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  pwm_pair_outstage #(.DT_W(DT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ch_raw(ch_raw), .dt_en(dt_en),
    .dt_len(dt_len), .inv_en(inv_en), .pol_en(pol_en), .oe_en(oe_en),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  // Cycle model written from the requirements (R2..R6, R10).
  logic [1:0] mq;
  int         mc [2];
  logic [1:0] dth;
  always @(posedge clk) begin
    if (!rst_n) begin
      mq = 2'b00; mc[0] = 0; mc[1] = 0; dth = 2'b00;
    end else begin
      dth = {dth[0], dt_en};
      for (int i = 0; i < 2; i++) begin
        logic s;
        s = !dt_en ? ch_raw[i] : (i == 0 ? ch_raw[0] : !ch_raw[0]);
        if (!dt_en)          begin mq[i] = s; mc[i] = 0; end
        else if (!s)         begin mq[i] = 1'b0; mc[i] = 0; end
        else if (!mq[i]) begin
          if (mc[i] == int'(dt_len)) mq[i] = 1'b1;
          else if (tick)             mc[i] = mc[i] + 1;
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input string tag);
    @(negedge clk);
    chk(tag, pin_out, mq ^ inv_en ^ pol_en);
    chk("R9 pin_oe", pin_oe, oe_en);
    if (dth == 2'b11 && inv_en == 2'b00 && pol_en == 2'b00)
      chk("R7 overlap", {1'b0, pin_out[0] & pin_out[1]}, 2'b00);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int cyc;
    int hi_seen;
    int rise_at;
    rst_n = 0; tick = 0; dt_en = 0; ch_raw = 2'b11; dt_len = '0;
    inv_en = 2'b01; pol_en = 2'b00; oe_en = 2'b10;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 reset pin_out", pin_out, 2'b01);
    chk("R9 reset pin_oe", pin_oe, 2'b10);
    inv_en = 2'b00; oe_en = 2'b11; ch_raw = 2'b00;
    @(negedge clk); rst_n = 1;

    // R2: pass-through of all raw patterns
    for (int k = 0; k < 12; k++) begin
      ch_raw = 2'(k * 3 + k / 4);
      step("R2 pass-through");
    end

    // R3 R4 R5 R6 R10: dead-time sweep; ch_raw[1] toggles freely
    cyc = 0;
    dt_en = 1;
    for (int len = 0; len <= 4; len++) begin
      for (int per = 1; per <= 3; per++) begin
        for (int w = 1; w <= 7; w++) begin
          dt_len = DT_W'(len);
          for (int t = 0; t < w + 8; t++) begin
            ch_raw[0] = (t < w);
            ch_raw[1] = cyc[0] ^ cyc[2];
            tick = (cyc % per) == 0;
            cyc++;
            step("R3 R4 R5 R6 R10 dead-time");
          end
        end
      end
    end

    // R4: explicit rise delay, interval 3, tick always high
    dt_len = 8'd3; tick = 1; ch_raw = 2'b00;
    repeat (4) step("R5 settle");
    ch_raw[0] = 1'b1; rise_at = -1;
    for (int t = 1; t <= 8; t++) begin
      step("R4 rise");
      if (rise_at < 0 && pin_out[0]) rise_at = t;
    end
    chk("R4 rise edge count", 2'(rise_at), 2'(4));
    ch_raw[0] = 1'b0;
    repeat (6) step("R5 fall");

    // R6: pulse of 4 with interval 5 never reaches the pin
    dt_len = 8'd5; hi_seen = 0;
    ch_raw[0] = 1'b1;
    for (int t = 0; t < 10; t++) begin
      if (t == 4) ch_raw[0] = 1'b0;
      step("R6 short pulse");
      if (pin_out[0]) hi_seen++;
    end
    chk("R6 output stayed low", 2'(hi_seen), 2'b00);

    // R10: no ticks -> no rise even after many edges (interval 2)
    dt_len = 8'd2; tick = 0; ch_raw[0] = 1'b1;
    repeat (12) step("R10 no tick");
    chk("R10 held low", {1'b0, pin_out[0]}, 2'b00);
    tick = 1;
    repeat (4) step("R10 ticks resume");

    // R8 R9: inversion and enable sweep, dt off, raw stable
    dt_en = 0; ch_raw = 2'b10;
    repeat (2) step("R2 settle");
    for (int c = 0; c < 64; c++) begin
      inv_en = 2'(c); pol_en = 2'(c >> 2); oe_en = 2'(c >> 4);
      #1;
      chk("R8 inversion", pin_out, 2'b10 ^ inv_en ^ pol_en);
      chk("R9 enable", pin_oe, oe_en);
      step("R8 R9 sweep");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule